// File: doc/BRIEF.md
# Indirect PHY Delay Register Bridge

This block lets software reach a bank of 64 byte-wide PHY delay registers through a single 32-bit control word. To write an entry, software stores a target index and a data byte in the word. It then sets the write strobe bit and polls the word until the acknowledge bit is set. Finally it clears the strobe, and the acknowledge bit then drops. A read works the same way through the read strobe. The fetched byte appears in a read-only field of the word and stays there until another read replaces it.

Each access is a four-phase handshake. The bridge captures the index, the data and the operation when it sees a strobe arrive in its idle state. It waits a fixed number of cycles, commits the access to the bank, and then holds acknowledge until both strobes are low. A strobe that is still held after the acknowledge starts nothing new. If both strobes are set together, the bank is left untouched and an error bit is raised, but acknowledge is still given so that software can finish the handshake.

The bank models a PHY that loses its contents in sleep. A pulse on the sleep input clears every entry to zero, so software must restore its delay settings after each wake-up. The control-word write and the sleep input are plain control pins with no back-pressure: a control-word write always lands on the clock edge where it is presented.

Top module: `phy_ind_bridge`

## Requirements
- R1: Control-word layout, with bit positions fixed. Bits [5:0] hold the entry index. Bits [15:8] hold the write byte. Bit 24 is the write strobe and bit 25 is the read strobe. All four read back as last written. Bits [7:6] and [31:28] always read zero. Writes to bits [23:16], 26 and 27 have no effect.
- R2: Bit 26 is the acknowledge. It rises ACC_LAT+1 clock edges after the edge that stores a strobe into an idle bridge (3 edges with the default ACC_LAT of 2).
- R3: Acknowledge stays high while either strobe is set. It falls on the first clock edge after a control-word write that clears both strobes.
- R4: While acknowledge is high, a held strobe starts no further access, even if the index or data fields are rewritten. Only a strobe that arrives while the bridge is idle starts an access.
- R5: A write access stores the write byte into the indexed entry and leaves every other entry unchanged. All 64 indices address distinct entries.
- R6: A read access places the indexed entry in bits [23:16] by the time acknowledge rises. That field keeps its value through later writes until the next read completes.
- R7: The index, byte and operation are captured when the access starts. Rewriting the control word while the access is pending does not change its target or data.
- R8: With both strobes set, no entry is written and the read field is kept. Bit 27 (error) is set when acknowledge rises and holds until the next access starts, which clears it.
- R9: After reset, all 64 entries are zero, and acknowledge, error, the read field and all writable fields are zero.
- R10: A one-cycle pulse on `phy_sleep` clears all 64 entries to zero. If the pulse lands on the same edge as a write commit, the clear wins and the entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_we | input | 1 | Control-word write enable, one cycle per write |
| cw_wdata | input | 32 | Value written to the control word |
| cw_rdata | output | 32 | Current control/status word as seen by software |
| phy_sleep | input | 1 | PHY retention loss pulse; clears the bank |

## Verification
Two pairs of events can fall on the same clock edge.

- **Sleep clear against write commit.** The commit edge is fixed at ACC_LAT+1 edges after the strobe is stored. The bench counts edges from the strobe write and places the sleep pulse exactly on the commit edge. It then judges the collision by reading the entry back and expecting zero.
- **Control-word rewrite against a pending access.** A rewrite of the control word can land inside the pending window of an access. The bench retargets the index and the data between the start and the commit. It then reads both the original and the new index to confirm that only the captured target changed.

// File: rtl/phyb_pkg.sv
package phyb_pkg;

  // Control word bit map; positions are software-visible behaviour
  localparam int CW_W        = 32;
  localparam int F_ADDR_LSB  = 0;
  localparam int F_ADDR_W    = 6;
  localparam int F_WDAT_LSB  = 8;
  localparam int F_BYTE_W    = 8;
  localparam int F_RDAT_LSB  = 16;
  localparam int B_WR_STB    = 24;
  localparam int B_RD_STB    = 25;
  localparam int B_ACK       = 26;
  localparam int B_ERR       = 27;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_BUSY = 2'd1,
    HS_DONE = 2'd2
  } hs_state_e;

endpackage

// File: rtl/phyb_reg_bank.sv
module phyb_reg_bank #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Retention loss takes priority over a write landing on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // R10: after a clear edge every entry, hence any index looked up, is zero
  a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rdata == '0));

endmodule

// File: rtl/phyb_ctrl_word.sv
module phyb_ctrl_word
  import phyb_pkg::*;
#(
  parameter int ADDR_W = F_ADDR_W,
  parameter int DATA_W = F_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [CW_W-1:0]   sw_wdata,
  input  logic              rd_cap,
  input  logic [DATA_W-1:0] rd_val,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_wdat,
  output logic              f_wr_stb,
  output logic              f_rd_stb,
  output logic [DATA_W-1:0] f_rdat
);

  // Software-writable fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_addr   <= '0;
      f_wdat   <= '0;
      f_wr_stb <= 1'b0;
      f_rd_stb <= 1'b0;
    end else if (sw_we) begin
      f_addr   <= sw_wdata[F_ADDR_LSB +: ADDR_W];
      f_wdat   <= sw_wdata[F_WDAT_LSB +: DATA_W];
      f_wr_stb <= sw_wdata[B_WR_STB];
      f_rd_stb <= sw_wdata[B_RD_STB];
    end
  end

  // Read-return field: only a completed read replaces it
  always_ff @(posedge clk) begin
    if (!rst_n)      f_rdat <= '0;
    else if (rd_cap) f_rdat <= rd_val;
  end

  // R6: the read field is held between read completions
  a_r6_rdat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cap |=> $stable(f_rdat));

endmodule

// File: rtl/phyb_hs_fsm.sv
module phyb_hs_fsm
  import phyb_pkg::*;
#(
  parameter int ADDR_W  = F_ADDR_W,
  parameter int DATA_W  = F_BYTE_W,
  parameter int ACC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdat,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdat,
  output logic              phy_we,
  output logic              rd_cap,
  output logic              ack,
  output logic              err
);
  localparam int CNT_W = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACC_LAT - 1);

  hs_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic              cap_wr, cap_rd;
  logic              commit;

  assign commit   = (st == HS_BUSY) && (cnt == CNT_LAST);
  assign phy_we   = commit && cap_wr && !cap_rd;
  assign rd_cap   = commit && cap_rd && !cap_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= HS_IDLE;
      cnt      <= '0;
      ack      <= 1'b0;
      err      <= 1'b0;
      cap_wr   <= 1'b0;
      cap_rd   <= 1'b0;
      phy_addr <= '0;
      phy_wdat <= '0;
    end else begin
      unique case (st)
        HS_IDLE: begin
          if (wr_stb || rd_stb) begin
            st       <= HS_BUSY;
            cnt      <= '0;
            err      <= 1'b0;
            cap_wr   <= wr_stb;
            cap_rd   <= rd_stb;
            phy_addr <= in_addr;
            phy_wdat <= in_wdat;
          end
        end
        HS_BUSY: begin
          if (cnt == CNT_LAST) begin
            st  <= HS_DONE;
            ack <= 1'b1;
            err <= cap_wr && cap_rd;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        HS_DONE: begin
          if (!wr_stb && !rd_stb) begin
            st  <= HS_IDLE;
            ack <= 1'b0;
          end
        end
        default: st <= HS_IDLE;
      endcase
    end
  end

  // R3: with both strobes low, acknowledge drops on the next edge
  a_r3_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_stb && !rd_stb) |=> !ack);

  // R2: acknowledge only ever rises out of the counted pending window
  a_r2_ack_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(st) == HS_BUSY));

endmodule

// File: rtl/phy_ind_bridge.sv
module phy_ind_bridge
  import phyb_pkg::*;
#(
  parameter int ACC_LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cw_we,
  input  logic [31:0] cw_wdata,
  output logic [31:0] cw_rdata,
  input  logic        phy_sleep
);
  localparam int AW = F_ADDR_W;
  localparam int DW = F_BYTE_W;

  logic [AW-1:0] f_addr, phy_addr;
  logic [DW-1:0] f_wdat, f_rdat, phy_wdat, bank_q;
  logic          f_wr_stb, f_rd_stb;
  logic          phy_we, rd_cap, ack, err;

  phyb_ctrl_word #(.ADDR_W(AW), .DATA_W(DW)) u_cw (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (cw_we),
    .sw_wdata (cw_wdata),
    .rd_cap   (rd_cap),
    .rd_val   (bank_q),
    .f_addr   (f_addr),
    .f_wdat   (f_wdat),
    .f_wr_stb (f_wr_stb),
    .f_rd_stb (f_rd_stb),
    .f_rdat   (f_rdat)
  );

  phyb_hs_fsm #(.ADDR_W(AW), .DATA_W(DW), .ACC_LAT(ACC_LAT)) u_hs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (f_wr_stb),
    .rd_stb   (f_rd_stb),
    .in_addr  (f_addr),
    .in_wdat  (f_wdat),
    .phy_addr (phy_addr),
    .phy_wdat (phy_wdat),
    .phy_we   (phy_we),
    .rd_cap   (rd_cap),
    .ack      (ack),
    .err      (err)
  );

  phyb_reg_bank #(.ADDR_W(AW), .DATA_W(DW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (phy_sleep),
    .we    (phy_we),
    .addr  (phy_addr),
    .wdata (phy_wdat),
    .rdata (bank_q)
  );

  assign cw_rdata = {4'b0000, err, ack, f_rd_stb, f_wr_stb,
                     f_rdat, f_wdat, 2'b00, f_addr};

  // R4: no bank activity while acknowledge is held
  a_r4_quiet_while_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !(phy_we || rd_cap));

  // R5: a committed write is followed by acknowledge
  a_r5_write_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
    phy_we |=> ack);

endmodule

// File: tb/phy_ind_bridge_test.sv
module phy_ind_bridge_test;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_we = 1'b0;
  logic        phy_sleep = 1'b0;
  logic [31:0] cw_wdata = '0;
  logic [31:0] cw_rdata;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  phy_ind_bridge #(.ACC_LAT(LAT)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_we     (cw_we),
    .cw_wdata  (cw_wdata),
    .cw_rdata  (cw_rdata),
    .phy_sleep (phy_sleep)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cw_raw(input logic [31:0] v);
    @(negedge clk); cw_we = 1'b1; cw_wdata = v;
    @(negedge clk); cw_we = 1'b0;
  endtask

  task automatic cw_put(input logic [5:0] a, input logic [7:0] d, input logic w, input logic r);
    cw_raw({6'b0, r, w, 8'h00, d, 2'b00, a});
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    while (!cw_rdata[26] && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic phy_write(input logic [5:0] a, input logic [7:0] d);
    int n;
    cw_put(a, d, 1'b0, 1'b0);
    cw_put(a, d, 1'b1, 1'b0);
    wait_ack(n);
    cw_put(a, d, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic phy_read(input logic [5:0] a, output logic [7:0] v);
    int n;
    cw_put(a, 8'h00, 1'b0, 1'b1);
    wait_ack(n);
    v = cw_rdata[23:16];
    cw_put(a, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R9 word after reset", cw_rdata, 32'h0);
    phy_read(6'h00, v); chk("R9 entry 00 zero", v, 8'h00);
    phy_read(6'h0D, v); chk("R9 entry 0D zero", v, 8'h00);
    phy_read(6'h3F, v); chk("R9 entry 3F zero", v, 8'h00);
  endtask

  task automatic t_layout;
    cw_put(6'h2A, 8'hC3, 1'b0, 1'b0);
    chk("R1 fields readback", cw_rdata, 32'h0000_C32A);
    cw_raw(32'hFCAB_00C0);
    chk("R1 reserved and read-only bits", cw_rdata, 32'h0000_0000);
  endtask

  task automatic t_ack_timing;
    int n;
    cw_put(6'h03, 8'h11, 1'b0, 1'b0);
    cw_put(6'h03, 8'h11, 1'b1, 1'b0);
    wait_ack(n);
    chk("R2 ack latency", n, LAT + 1);
    chk("R2 ack bit", cw_rdata[26], 1'b1);
    cw_put(6'h03, 8'h11, 1'b0, 1'b0);
    chk("R3 ack held until edge", cw_rdata[26], 1'b1);
    @(negedge clk);
    chk("R3 ack dropped", cw_rdata[26], 1'b0);
  endtask

  task automatic t_write_read;
    logic [7:0] v;
    logic [5:0] idx [12] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05,
                             6'h06, 6'h07, 6'h08, 6'h0B, 6'h0C, 6'h0D};
    for (int i = 0; i < 12; i++) phy_write(idx[i], 8'h40 + 8'(i * 7));
    phy_write(6'h3F, 8'hA5);
    for (int i = 0; i < 12; i++) begin
      phy_read(idx[i], v);
      chk("R5 entry readback", v, 8'h40 + 8'(i * 7));
    end
    phy_read(6'h3F, v); chk("R5 top index distinct", v, 8'hA5);
    phy_read(6'h09, v); chk("R5 untouched entry", v, 8'h00);
    phy_read(6'h0B, v);
    phy_write(6'h0C, 8'h99);
    chk("R6 read field held over write", cw_rdata[23:16], 8'h40 + 8'(9 * 7));
  endtask

  task automatic t_hold;
    int n;
    logic [7:0] v;
    cw_put(6'h07, 8'h22, 1'b1, 1'b0);
    wait_ack(n);
    cw_put(6'h07, 8'h99, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    chk("R4 ack stays with held strobe", cw_rdata[26], 1'b1);
    cw_put(6'h07, 8'h99, 1'b0, 1'b0);
    @(negedge clk);
    phy_read(6'h07, v);
    chk("R4 no second access", v, 8'h22);
  endtask

  task automatic t_capture;
    int n;
    logic [7:0] v;
    phy_write(6'h09, 8'h00);
    cw_put(6'h08, 8'h44, 1'b1, 1'b0);
    cw_put(6'h09, 8'hEE, 1'b1, 1'b0);
    wait_ack(n);
    cw_put(6'h09, 8'hEE, 1'b0, 1'b0);
    @(negedge clk);
    phy_read(6'h08, v); chk("R7 captured target written", v, 8'h44);
    phy_read(6'h09, v); chk("R7 retarget ignored", v, 8'h00);
  endtask

  task automatic t_clash;
    int n;
    logic [7:0] v;
    phy_read(6'h08, v);
    cw_put(6'h08, 8'h55, 1'b1, 1'b1);
    wait_ack(n);
    chk("R8 ack given on clash", n, LAT + 1);
    chk("R8 error bit", cw_rdata[27], 1'b1);
    chk("R8 read field kept", cw_rdata[23:16], 8'h44);
    cw_put(6'h08, 8'h55, 1'b0, 1'b0);
    @(negedge clk);
    chk("R8 error holds after handshake", cw_rdata[27], 1'b1);
    phy_read(6'h08, v);
    chk("R8 entry not written", v, 8'h44);
    chk("R8 error cleared by next access", cw_rdata[27], 1'b0);
  endtask

  task automatic t_sleep;
    int n;
    logic [7:0] v;
    phy_write(6'h06, 8'h66);
    @(negedge clk); phy_sleep = 1'b1;
    @(negedge clk); phy_sleep = 1'b0;
    phy_read(6'h06, v); chk("R10 idle clear", v, 8'h00);
    phy_read(6'h3F, v); chk("R10 idle clear top", v, 8'h00);
    cw_put(6'h05, 8'h77, 1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    phy_sleep = 1'b1;
    @(negedge clk);
    phy_sleep = 1'b0;
    wait_ack(n);
    chk("R10 ack on collided write", cw_rdata[26], 1'b1);
    cw_put(6'h05, 8'h77, 1'b0, 1'b0);
    @(negedge clk);
    phy_read(6'h05, v); chk("R10 clear wins over commit", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_ack_timing();
    t_write_read();
    t_hold();
    t_capture();
    t_clash();
    t_sleep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule